// File: doc/BRIEF.md
# Tag Compare and Fill-Write Unit

This block holds a small tag memory. On each clock edge it decodes one operation from its strobes. A lookup with data enable active latches the word on the bus into a held-tag register. It then compares that held tag with the stored word at the registered address and reports the result on an active-low match flag (low means hit). After a miss, the host can issue a fill write. The fill write stores the held tag at the addressed word, so the host does not have to drive the tag onto the bus again. The unit also supports plain reads and plain writes.

The decoded operation is registered in a small state register with five states. OP_DESEL is entered when chip enable is inactive. When chip enable is active, the strobes select the state: OP_WRITE (write and data enable both active), OP_FILL (write active, data enable inactive), OP_CMP (write inactive, data enable active) and OP_READ (write and data enable both inactive). Any state can move to any other state on every edge; the transition is chosen only by the strobes sampled at that edge. A static mode input selects where results come from. In flow-through mode they come straight from the registered state. In pipelined mode they come from a second output stage one cycle later. The output enable and the match output enable gate the two output drivers without a clock. The drivers are modelled as value-plus-enable pairs.

Top module: `tag_cmp_fill`

## Requirements
- R1: The held-tag register loads `dq_in` on every edge where `de_n` is low and keeps its value on edges where `de_n` is high.
- R2: A cycle with `ce_n`, `wr_n` and `de_n` all low stores `dq_in` at `addr`. While that write is the presented operation, `dq_oe` stays low even with `oe_n` low.
- R3: A cycle with `ce_n` low and `wr_n`, `de_n` high is a read. While it is presented, `dq_out` carries the stored word and `dq_oe` equals the inverse of `oe_n`.
- R4: A cycle with `ce_n` low, `wr_n` high and `de_n` low is a compare. While it is presented, `match_n` is 0 exactly when the stored word equals the latched tag. A presented read never shows a hit.
- R5: A cycle with `ce_n` low, `wr_n` low and `de_n` high is a fill write. It stores the held tag at `addr` and leaves the held tag unchanged, so a following compare of that tag hits.
- R6: While a deselect (`ce_n` high) is the presented operation, `match_n` is 1.
- R7: With `flow_thru` = 1, results are presented in the cycle right after the sampling edge. With `flow_thru` = 0, they are presented one cycle later.
- R8: `match_en` follows the inverse of `moe_n`, and `dq_oe` falls when `oe_n` rises. Both take effect with no clock edge in between.
- R9: During and right after reset, `dq_oe` is 0 and `match_n` is 1.
- R10: The compare covers all 18 bits. A tag that differs from the stored word only in bit 17 is a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flow_thru | input | 1 | 1 = flow-through results, 0 = pipelined results |
| ce_n | input | 1 | Active-low chip enable |
| wr_n | input | 1 | Active-low write strobe |
| de_n | input | 1 | Active-low data enable (gates the held-tag register) |
| oe_n | input | 1 | Active-low output enable, not clocked |
| moe_n | input | 1 | Active-low match output enable, not clocked |
| addr | input | AW | Word address, sampled at the edge |
| dq_in | input | 18 | Write data or tag |
| dq_out | output | 18 | Read data |
| dq_oe | output | 1 | Data driver enable |
| match_n | output | 1 | Match flag, low = hit |
| match_en | output | 1 | Match driver enable (low = high impedance) |

## Verification
In flow-through mode, every result of an operation sampled at edge N is valid from edge N until edge N+1. The bench drives inputs at falling edges and reads the result at the falling edge that follows. In pipelined mode the same result appears one edge later. The bench therefore issues a deselect right after the operation and reads at the second falling edge. It also checks that the first falling edge still shows the previous operation. The two enable gates are checked a few nanoseconds after they toggle, within a single clock phase, which shows that no edge is involved.

// File: rtl/tcf_pkg.sv
package tcf_pkg;
    typedef enum logic [2:0] {
        OP_DESEL = 3'd0,
        OP_READ  = 3'd1,
        OP_CMP   = 3'd2,
        OP_WRITE = 3'd3,
        OP_FILL  = 3'd4
    } tcf_op_e;
endpackage

// File: rtl/tcf_ctrl.sv
module tcf_ctrl
    import tcf_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    ce_n,
    input  logic    wr_n,
    input  logic    de_n,
    output tcf_op_e op_q,
    output logic    mem_we,
    output logic    use_held,
    output logic    tag_load
);
    tcf_op_e op_nxt;

    // next-operation decode
    always_comb begin
        op_nxt = OP_DESEL;
        if (!ce_n) begin
            unique case ({wr_n, de_n})
                2'b00:   op_nxt = OP_WRITE;
                2'b01:   op_nxt = OP_FILL;
                2'b10:   op_nxt = OP_CMP;
                2'b11:   op_nxt = OP_READ;
                default: op_nxt = OP_DESEL;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) op_q <= OP_DESEL;
        else        op_q <= op_nxt;
    end

    // per-edge control outputs
    always_comb begin
        mem_we   = 1'b0;
        use_held = 1'b0;
        unique case (op_nxt)
            OP_WRITE: mem_we = 1'b1;
            OP_FILL: begin
                mem_we   = 1'b1;
                use_held = 1'b1;
            end
            default: ;
        endcase
        tag_load = !de_n;
    end
endmodule

// File: rtl/tcf_inreg.sv
module tcf_inreg #(
    parameter int DW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] d,
    output logic [DW-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= d;
    end
endmodule

// File: rtl/tcf_array.sv
module tcf_array #(
    parameter int DW    = 18,
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata <= '0;
        else        rdata <= mem[addr];
    end
endmodule

// File: rtl/tcf_outstage.sv
module tcf_outstage
    import tcf_pkg::*;
#(
    parameter int DW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flow_thru,
    input  tcf_op_e       op_q,
    input  logic [DW-1:0] rd_q,
    input  logic [DW-1:0] tag_q,
    output tcf_op_e       op_show,
    output logic [DW-1:0] rd_show,
    output logic          hit_show
);
    tcf_op_e       op_p;
    logic [DW-1:0] rd_p;
    logic          hit_p;
    logic          hit_now;

    assign hit_now = (rd_q == tag_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_p  <= OP_DESEL;
            rd_p  <= '0;
            hit_p <= 1'b0;
        end else begin
            op_p  <= op_q;
            rd_p  <= rd_q;
            hit_p <= hit_now;
        end
    end

    always_comb begin
        if (flow_thru) begin
            op_show  = op_q;
            rd_show  = rd_q;
            hit_show = hit_now;
        end else begin
            op_show  = op_p;
            rd_show  = rd_p;
            hit_show = hit_p;
        end
    end
endmodule

// File: rtl/tag_cmp_fill.sv
module tag_cmp_fill
    import tcf_pkg::*;
#(
    parameter int DW    = 18,
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flow_thru,
    input  logic          ce_n,
    input  logic          wr_n,
    input  logic          de_n,
    input  logic          oe_n,
    input  logic          moe_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] dq_in,
    output logic [DW-1:0] dq_out,
    output logic          dq_oe,
    output logic          match_n,
    output logic          match_en
);
    tcf_op_e       op_q;
    tcf_op_e       op_show;
    logic          mem_we;
    logic          use_held;
    logic          tag_load;
    logic [DW-1:0] tag_q;
    logic [DW-1:0] rd_q;
    logic [DW-1:0] wdata;
    logic          hit_show;

    tcf_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_n     (ce_n),
        .wr_n     (wr_n),
        .de_n     (de_n),
        .op_q     (op_q),
        .mem_we   (mem_we),
        .use_held (use_held),
        .tag_load (tag_load)
    );

    tcf_inreg #(.DW(DW)) u_inreg (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tag_load),
        .d     (dq_in),
        .q     (tag_q)
    );

    assign wdata = use_held ? tag_q : dq_in;

    tcf_array #(.DW(DW), .DEPTH(DEPTH)) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rd_q)
    );

    tcf_outstage #(.DW(DW)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .flow_thru (flow_thru),
        .op_q      (op_q),
        .rd_q      (rd_q),
        .tag_q     (tag_q),
        .op_show   (op_show),
        .rd_show   (rd_show_w),
        .hit_show  (hit_show)
    );

    logic [DW-1:0] rd_show_w;

    // driver gating, not clocked
    always_comb begin
        dq_out   = rd_show_w;
        dq_oe    = !oe_n && (op_show == OP_READ);
        match_n  = !((op_show == OP_CMP) && hit_show);
        match_en = !moe_n;
    end
endmodule

// File: rtl/tag_cmp_fill_chk.sv
module tag_cmp_fill_chk (
    input logic clk,
    input logic rst_n,
    input logic flow_thru,
    input logic ce_n,
    input logic wr_n,
    input logic de_n,
    input logic oe_n,
    input logic moe_n,
    input logic dq_oe,
    input logic match_n
);
    logic [1:0] age;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            age <= 2'd0;
        else if (age != 2'd3)  age <= age + 2'd1;
    end

    // R6: deselect presented in flow-through mode shows no match
    a_r6_desel_flow: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 2'd1 && flow_thru && $past(ce_n) && !moe_n) |-> match_n);

    // R6, R7: deselect presented one cycle later in pipelined mode
    a_r7_desel_pipe: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 2'd2 && !flow_thru && $past(ce_n, 2) && !moe_n) |-> match_n);

    // R4: a plain read never reports a hit
    a_r4_read_nohit: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 2'd1 && flow_thru && $past(!ce_n && wr_n && de_n)) |-> match_n);

    // R2: no data drive while a write is presented
    a_r2_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 2'd1 && flow_thru && $past(!ce_n && !wr_n)) |-> !dq_oe);

    // R8: data driver never on while output enable is inactive
    always_comb begin
        if (rst_n) begin
            a_r8_oe_gate: assert (!(dq_oe && oe_n));
        end
    end
endmodule

bind tag_cmp_fill tag_cmp_fill_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .flow_thru (flow_thru),
    .ce_n      (ce_n),
    .wr_n      (wr_n),
    .de_n      (de_n),
    .oe_n      (oe_n),
    .moe_n     (moe_n),
    .dq_oe     (dq_oe),
    .match_n   (match_n)
);

// File: tb/tag_cmp_fill_bench.sv
module tag_cmp_fill_bench;
    localparam int DW    = 18;
    localparam int DEPTH = 256;
    localparam int AW    = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flow_thru = 1'b1;
    logic          ce_n = 1'b1;
    logic          wr_n = 1'b1;
    logic          de_n = 1'b1;
    logic          oe_n = 1'b1;
    logic          moe_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] dq_in = '0;
    logic [DW-1:0] dq_out;
    logic          dq_oe;
    logic          match_n;
    logic          match_en;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    tag_cmp_fill u_tag_cmp_fill (
        .clk       (clk),
        .rst_n     (rst_n),
        .flow_thru (flow_thru),
        .ce_n      (ce_n),
        .wr_n      (wr_n),
        .de_n      (de_n),
        .oe_n      (oe_n),
        .moe_n     (moe_n),
        .addr      (addr),
        .dq_in     (dq_in),
        .dq_out    (dq_out),
        .dq_oe     (dq_oe),
        .match_n   (match_n),
        .match_en  (match_en)
    );

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive one operation at a falling edge, return at the next falling edge
    task automatic step(input logic c, input logic w, input logic d,
                        input logic [AW-1:0] a, input logic [DW-1:0] v);
        ce_n = c; wr_n = w; de_n = d; addr = a; dq_in = v;
        @(negedge clk);
    endtask

    task automatic idle();
        step(1'b1, 1'b1, 1'b1, '0, 18'h3FFFF);
    endtask

    task automatic t_reset();
        #5;
        chk("R9 dq_oe in reset", {17'd0, dq_oe}, 18'd0);
        chk("R9 match_n in reset", {17'd0, match_n}, 18'd1);
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 match_n after reset", {17'd0, match_n}, 18'd1);
    endtask

    task automatic t_write_read();
        oe_n = 1'b0;
        step(1'b0, 1'b0, 1'b0, 8'd5, 18'h2A5A5);
        chk("R2 no drive during write", {17'd0, dq_oe}, 18'd0);
        step(1'b0, 1'b1, 1'b1, 8'd5, 18'h00000);
        chk("R3 read drive", {17'd0, dq_oe}, 18'd1);
        chk("R3 read data", dq_out, 18'h2A5A5);
        chk("R4 read shows no hit", {17'd0, match_n}, 18'd1);
        oe_n = 1'b1; #2;
        chk("R8 oe_n gates without clock", {17'd0, dq_oe}, 18'd0);
        @(negedge clk);
    endtask

    task automatic t_compare_fill();
        oe_n = 1'b1;
        step(1'b0, 1'b1, 1'b0, 8'd5, 18'h2A5A5);
        chk("R4 compare hit", {17'd0, match_n}, 18'd0);
        moe_n = 1'b1; #2;
        chk("R8 moe_n off without clock", {17'd0, match_en}, 18'd0);
        moe_n = 1'b0; #2;
        chk("R8 moe_n on without clock", {17'd0, match_en}, 18'd1);
        idle();
        chk("R6 deselect no match", {17'd0, match_n}, 18'd1);
        step(1'b0, 1'b1, 1'b0, 8'd5, 18'h0A5A5);
        chk("R10 bit17 difference misses", {17'd0, match_n}, 18'd1);
        idle();   // bus carries other data with de_n high
        step(1'b0, 1'b0, 1'b1, 8'd5, 18'h11111);
        step(1'b0, 1'b1, 1'b0, 8'd5, 18'h0A5A5);
        chk("R5 compare after fill hits", {17'd0, match_n}, 18'd0);
        oe_n = 1'b0;
        step(1'b0, 1'b1, 1'b1, 8'd5, 18'h22222);
        chk("R1 fill stored held tag not bus", dq_out, 18'h0A5A5);
        oe_n = 1'b1;
        idle();
    endtask

    task automatic t_pipeline();
        flow_thru = 1'b0;
        idle(); idle();
        step(1'b0, 1'b1, 1'b0, 8'd5, 18'h0A5A5);
        chk("R7 pipelined hit not yet shown", {17'd0, match_n}, 18'd1);
        idle();
        chk("R7 pipelined hit one cycle later", {17'd0, match_n}, 18'd0);
        idle();
        chk("R6 pipelined deselect", {17'd0, match_n}, 18'd1);
        oe_n = 1'b0;
        step(1'b0, 1'b1, 1'b1, 8'd5, 18'h00000);
        chk("R7 pipelined read not yet driven", {17'd0, dq_oe}, 18'd0);
        idle();
        chk("R7 pipelined read data", dq_out, 18'h0A5A5);
        chk("R3 pipelined read drive", {17'd0, dq_oe}, 18'd1);
        oe_n = 1'b1;
        step(1'b0, 1'b1, 1'b0, 8'd5, 18'h1A5A5);
        idle();
        chk("R10 pipelined bit16 difference misses", {17'd0, match_n}, 18'd1);
    endtask

    initial begin
        #4_000_000;
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_write_read();
        t_compare_fill();
        t_pipeline();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule